// File: doc/BRIEF.md
# SPI Slave-Select Output Controller

This block drives a bank of active-low slave-select pins for an SPI master, together with an output enable for each pin. Software picks which lines serve as selects through a line-enable register and can place a chosen level on each line through a line-level register. Both registers sit on a small synchronous write/read bus.

The clock-phase bit decides who owns the enabled lines. With the phase bit at 1, every enabled pin follows its software level bit, so software can hold a select low across many words or pulse it between words. With the phase bit at 0, the level bits are ignored and a two-state word tracker owns every enabled pin. The tracker has the states `WS_IDLE` (select released high) and `WS_SHIFT` (select asserted low). The transition `WS_IDLE -> WS_SHIFT` fires on the shift engine's word-start strobe. The transition `WS_SHIFT -> WS_IDLE` fires on its word-end strobe. The pin is therefore released between every pair of words.

Outputs are combinational from the registers and the tracker state. A strobe or write sampled at a clock edge shows on the pins right after that edge.

Top module: `ssel_ctrl`

## Requirements
- R1: After reset every output enable is 0, every select pin is 1, the line-enable register reads 0 and the line-level register reads all ones.
- R2: Output enable bit i equals line-enable bit i. A disabled line's select pin sits at 1 whatever the phase, level or strobes.
- R3: With the phase bit at 1, each enabled select pin equals its level bit (0 drives low, 1 drives high) from the edge that writes the level.
- R4: With the phase bit at 1, word-start and word-end strobes leave the pins unchanged, so a level of 0 keeps a line low across consecutive words.
- R5: With the phase bit at 0, the level bits have no effect: an enabled pin is high while no word is in progress, even with its level bit at 0.
- R6: With the phase bit at 0, enabled pins go low after the edge that samples word-start (`WS_IDLE -> WS_SHIFT`), stay low until the edge that samples word-end, and go high after it (`WS_SHIFT -> WS_IDLE`).
- R7: In `WS_SHIFT`, word-end wins over a word-start in the same cycle. The pins go high and the tracker stays in `WS_IDLE` until a later word-start. In `WS_IDLE`, word-start wins over a simultaneous word-end.
- R8: Address 0 reads and writes the line-enable register and address 1 the line-level register, one bit per line, line i at bit i. Writes to any other address change nothing, and reads there return 0.
- R9: With the phase bit at 0, setting only an enable bit (the level register untouched since reset) is enough for that line to follow the word strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpha | input | 1 | Clock-phase bit: 1 = software-owned lines, 0 = hardware-owned lines |
| word_start | input | 1 | One-cycle strobe from the shift engine: a word begins |
| word_end | input | 1 | One-cycle strobe from the shift engine: a word has finished |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address (0 = enable, 1 = level) |
| bus_wdata | input | NUM_SEL | Write data |
| bus_rdata | output | NUM_SEL | Read data for `bus_addr`, combinational |
| ssel_n | output | NUM_SEL | Active-low slave-select levels |
| ssel_oe | output | NUM_SEL | Per-line output enables |

## Verification
The bench builds the block with its defaults: seven select lines and a two-bit address. The two-bit address leaves two unused addresses available to show that writes there change nothing. With seven lines, a sparse enable pattern can hold enabled and disabled lines side by side, so each check shows hardware or software ownership on the enabled lines while the disabled ones stay released. The directed scenarios cover both phase settings, a word-end and word-start in the same cycle from each tracker state, and pulsing a line between words under software control.

// File: rtl/ssel_pkg.sv
package ssel_pkg;
    typedef enum logic {
        WS_IDLE  = 1'b0,
        WS_SHIFT = 1'b1
    } word_state_e;
endpackage

// File: rtl/ssel_regs.sv
module ssel_regs #(
    parameter int NUM_SEL = 7,
    parameter int ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [NUM_SEL-1:0] wdata,
    output logic [NUM_SEL-1:0] rdata,
    output logic [NUM_SEL-1:0] line_en,
    output logic [NUM_SEL-1:0] line_lvl
);
    localparam logic [ADDR_W-1:0] ADDR_EN  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_LVL = ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_en  <= '0;
            line_lvl <= '1;
        end else if (wr_en) begin
            if (addr == ADDR_EN)  line_en  <= wdata;
            if (addr == ADDR_LVL) line_lvl <= wdata;
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_EN:  rdata = line_en;
            ADDR_LVL: rdata = line_lvl;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/ssel_fsm.sv
module ssel_fsm
    import ssel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic word_start,
    input  logic word_end,
    output logic active
);
    word_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= WS_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:  if (word_start) state_d = WS_SHIFT;
            WS_SHIFT: if (word_end)   state_d = WS_IDLE;
            default:  state_d = WS_IDLE;
        endcase
    end

    always_comb begin
        active = (state_q == WS_SHIFT);
    end
endmodule

// File: rtl/ssel_drive.sv
module ssel_drive #(
    parameter int NUM_SEL = 7
) (
    input  logic               cpha,
    input  logic               active,
    input  logic [NUM_SEL-1:0] line_en,
    input  logic [NUM_SEL-1:0] line_lvl,
    output logic [NUM_SEL-1:0] ssel_n,
    output logic [NUM_SEL-1:0] ssel_oe
);
    for (genvar i = 0; i < NUM_SEL; i++) begin : g_line
        always_comb begin
            ssel_oe[i] = line_en[i];
            if (!line_en[i])  ssel_n[i] = 1'b1;
            else if (cpha)    ssel_n[i] = line_lvl[i];
            else              ssel_n[i] = ~active;
        end
    end
endmodule

// File: rtl/ssel_ctrl.sv
module ssel_ctrl #(
    parameter int NUM_SEL = 7,
    parameter int ADDR_W  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cpha,
    input  logic               word_start,
    input  logic               word_end,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [NUM_SEL-1:0] bus_wdata,
    output logic [NUM_SEL-1:0] bus_rdata,
    output logic [NUM_SEL-1:0] ssel_n,
    output logic [NUM_SEL-1:0] ssel_oe
);
    logic [NUM_SEL-1:0] line_en;
    logic [NUM_SEL-1:0] line_lvl;
    logic               active;

    ssel_regs #(.NUM_SEL(NUM_SEL), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .line_en  (line_en),
        .line_lvl (line_lvl)
    );

    ssel_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .word_start (word_start),
        .word_end   (word_end),
        .active     (active)
    );

    ssel_drive #(.NUM_SEL(NUM_SEL)) u_drive (
        .cpha     (cpha),
        .active   (active),
        .line_en  (line_en),
        .line_lvl (line_lvl),
        .ssel_n   (ssel_n),
        .ssel_oe  (ssel_oe)
    );
endmodule

// File: rtl/ssel_ctrl_chk.sv
module ssel_ctrl_chk #(
    parameter int NUM_SEL = 7,
    parameter int ADDR_W  = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               cpha,
    input logic               word_start,
    input logic               word_end,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [NUM_SEL-1:0] bus_wdata,
    input logic [NUM_SEL-1:0] bus_rdata,
    input logic [NUM_SEL-1:0] ssel_n,
    input logic [NUM_SEL-1:0] ssel_oe
);
    a_r1_reset_released: assert property (@(posedge clk)
        rst |=> (ssel_oe == '0 && ssel_n == '1));

    a_r2_disabled_high: assert property (@(posedge clk) disable iff (rst)
        ((ssel_n | ssel_oe) == '1));

    a_r4_sw_pins_hold: assert property (@(posedge clk) disable iff (rst)
        (cpha && !bus_wr) |=> (!cpha || $stable(ssel_n)));

    a_r6_start_asserts: assert property (@(posedge clk) disable iff (rst)
        (!cpha && word_start && !word_end && !bus_wr) |=> (cpha || (ssel_n & ssel_oe) == '0));

    a_r7_end_releases: assert property (@(posedge clk) disable iff (rst)
        (word_end && !word_start) |=> (cpha || ssel_n == '1));

    a_r8_level_readback: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(1)) |=> (bus_addr != ADDR_W'(1) || bus_rdata == $past(bus_wdata)));
endmodule

bind ssel_ctrl ssel_ctrl_chk #(.NUM_SEL(NUM_SEL), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpha       (cpha),
    .word_start (word_start),
    .word_end   (word_end),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .ssel_n     (ssel_n),
    .ssel_oe    (ssel_oe)
);

// File: tb/ssel_ctrl_tb.sv
module ssel_ctrl_tb;
    localparam int NUM_SEL = 7;
    localparam int ADDR_W  = 2;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cpha = 1'b0;
    logic               word_start = 1'b0;
    logic               word_end = 1'b0;
    logic               bus_wr = 1'b0;
    logic [ADDR_W-1:0]  bus_addr = '0;
    logic [NUM_SEL-1:0] bus_wdata = '0;
    logic [NUM_SEL-1:0] bus_rdata;
    logic [NUM_SEL-1:0] ssel_n;
    logic [NUM_SEL-1:0] ssel_oe;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    ssel_ctrl #(.NUM_SEL(NUM_SEL), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst(rst), .cpha(cpha),
        .word_start(word_start), .word_end(word_end),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ssel_n(ssel_n), .ssel_oe(ssel_oe)
    );

    task automatic chk(input string req, input logic [NUM_SEL-1:0] act, input logic [NUM_SEL-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [NUM_SEL-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [NUM_SEL-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic strobe(input logic s, input logic e);
        word_start = s; word_end = e;
        @(negedge clk);
        word_start = 1'b0; word_end = 1'b0;
    endtask

    task automatic t_reset();
        logic [NUM_SEL-1:0] d;
        chk("R1 oe", ssel_oe, 7'h00);
        chk("R1 ssel_n", ssel_n, 7'h7F);
        rd(0, d); chk("R1 enable reg", d, 7'h00);
        rd(1, d); chk("R1 level reg", d, 7'h7F);
    endtask

    task automatic t_hw_enable_only();
        cpha = 1'b0;
        wr(0, 7'h05);
        chk("R2 oe follows enable", ssel_oe, 7'h05);
        chk("R9 idle high", ssel_n, 7'h7F);
        strobe(1'b1, 1'b0);
        chk("R9 enable-only asserts", ssel_n, 7'h7A);
        strobe(1'b0, 1'b1);
        chk("R9 enable-only releases", ssel_n, 7'h7F);
    endtask

    task automatic t_hw_word();
        cpha = 1'b0;
        wr(1, 7'h00);
        chk("R5 level ignored idle", ssel_n, 7'h7F);
        strobe(1'b1, 1'b0);
        chk("R6 low after start", ssel_n, 7'h7A);
        @(negedge clk); @(negedge clk);
        chk("R6 low mid word", ssel_n, 7'h7A);
        strobe(1'b0, 1'b1);
        chk("R6 high after end", ssel_n, 7'h7F);
        @(negedge clk);
        chk("R6 stays high", ssel_n, 7'h7F);
    endtask

    task automatic t_back_to_back();
        cpha = 1'b0;
        strobe(1'b1, 1'b0);
        chk("R7 first word low", ssel_n, 7'h7A);
        strobe(1'b1, 1'b1);
        chk("R7 end wins in shift", ssel_n, 7'h7F);
        @(negedge clk);
        chk("R7 remains idle", ssel_n, 7'h7F);
        strobe(1'b1, 1'b1);
        chk("R7 start wins in idle", ssel_n, 7'h7A);
        strobe(1'b0, 1'b1);
        chk("R7 release", ssel_n, 7'h7F);
    endtask

    task automatic t_sw_mode();
        cpha = 1'b1;
        wr(1, 7'h7F);
        chk("R3 level high", ssel_n, 7'h7F);
        wr(1, 7'h7E);
        chk("R3 line0 low", ssel_n, 7'h7E);
        wr(1, 7'h00);
        chk("R3 enabled low, disabled high", ssel_n, 7'h7A);
        strobe(1'b1, 1'b0);
        chk("R4 start no effect", ssel_n, 7'h7A);
        strobe(1'b0, 1'b1);
        chk("R4 end no effect", ssel_n, 7'h7A);
        strobe(1'b1, 1'b0);
        strobe(1'b0, 1'b1);
        chk("R4 held across words", ssel_n, 7'h7A);
        wr(1, 7'h01);
        chk("R3 pulse high", ssel_n, 7'h7B);
        wr(1, 7'h00);
        chk("R3 pulse low", ssel_n, 7'h7A);
    endtask

    task automatic t_disabled();
        cpha = 1'b1;
        wr(0, 7'h04);
        chk("R2 oe", ssel_oe, 7'h04);
        chk("R2 disabled high", ssel_n, 7'h7B);
        cpha = 1'b0;
        strobe(1'b1, 1'b0);
        chk("R2 disabled high in word", ssel_n, 7'h7B);
        strobe(1'b0, 1'b1);
    endtask

    task automatic t_regs();
        logic [NUM_SEL-1:0] d;
        wr(0, 7'h2A);
        wr(1, 7'h55);
        wr(2, 7'h7F);
        wr(3, 7'h7F);
        rd(0, d); chk("R8 enable readback", d, 7'h2A);
        rd(1, d); chk("R8 level readback", d, 7'h55);
        rd(2, d); chk("R8 addr2 reads 0", d, 7'h00);
        rd(3, d); chk("R8 addr3 reads 0", d, 7'h00);
        chk("R8 oe unchanged", ssel_oe, 7'h2A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_hw_enable_only();
        t_hw_word();
        t_back_to_back();
        t_sw_mode();
        t_disabled();
        t_regs();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule